// File: doc/BRIEF.md
# Two-Phase Watchdog Timer with Pre-Timeout Interrupt

This block is a watchdog that measures time in coarse ticks. A fixed power-of-two divider sets the base tick length, and a 2-bit prescale field stretches each tick by a factor of 1, 2, 4 or 8. Once software enables it, the watchdog runs through two phases one after the other. When the first phase expires, the watchdog sets an interrupt status flag and asserts its interrupt line. When the second phase expires, the watchdog sends a one-cycle reset request on one of three outputs, picked by a mode field. After that request it returns to its idle, disabled state.

Software programs the timer through a small register port. A control word holds the enable bit, the prescale, the reset mode and both phase lengths. Writing a fixed key word to the kick address puts the timer back at the start of the first phase. The status word holds the pending interrupt, which software clears by writing a one to that bit. The status word also shows the lock flag. Once the first phase has expired the watchdog is locked: software can no longer stop it by clearing enable, and only the reset request or a system reset releases the lock.

Top module: `wdt_two_phase`

## Requirements
- R1: After the synchronous active-low reset, irq_o and all three reset outputs are low, and the control word (address 0) and the status word (address 2) both read zero.
- R2: One tick lasts 2^(BASE_SHIFT+P) clock cycles, where P is control bits [2:1]. With phase-1 length F in control bits [12:8], irq_o goes high exactly (F+1)·2^(BASE_SHIFT+P) cycles after the clock edge that writes enable (control bit 0) to one.
- R3: When the first phase expires, status bit 0 becomes one and irq_o becomes high in the same cycle. Status bit 1 (lock) also becomes one at that point.
- R4: With phase-2 length S in control bits [20:16], the reset request arrives (S+1) ticks after the first phase expires. It lasts exactly one cycle, and afterwards the enable bit reads zero.
- R5: Control bits [4:3] choose the reset output: 0 selects rst_cpu_o, 1 selects rst_soc_o, and 2 or 3 select rst_full_o. No more than one reset output is ever high.
- R6: While the lock is set, writing zero to the enable bit does not stop the timer, and the reset request still comes at its scheduled cycle.
- R7: Writing the key 32'h5A5A_0001 to address 1 restarts the first phase. The next interrupt comes a full first-phase length after the kick edge, and this holds even when the kick lands in the second phase.
- R8: A write to address 1 with any value other than the key has no effect on the timing.
- R9: Writing a one to status bit 0 clears the pending interrupt and drops irq_o. Writing a zero there leaves it set.
- R10: While the timer is disabled and unlocked, it produces no interrupt and no reset. Enabling it again starts timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 kick, 2 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_o | output | 1 | First-phase interrupt, level, follows status bit 0 |
| rst_cpu_o | output | 1 | One-cycle reset request, mode 0 |
| rst_soc_o | output | 1 | One-cycle reset request, mode 1 |
| rst_full_o | output | 1 | One-cycle reset request, modes 2 and 3 |

## Verification
The main timing path runs once for every prescale setting, each with its own pair of phase lengths and its own reset mode. A wrong tick exponent, a phase counter off by one, or a swapped reset decode therefore each produce a different measured cycle count or a different output. Directed sequences then test whether a write reaches the timer: a wrong key against the real key (once in each phase), a disable before expiry against a disable after expiry, and a zero written to the interrupt flag against a one.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the two-phase watchdog.
// Assumes a 32-bit register word; field positions are fixed here.
package wdt_pkg;
    localparam int PHASE_W   = 5;
    localparam int PRESC_W   = 2;
    localparam int MODE_W    = 2;
    localparam int NUM_RST   = 3;

    localparam int EN_BIT    = 0;
    localparam int PRESC_LSB = 1;
    localparam int MODE_LSB  = 3;
    localparam int PH1_LSB   = 8;
    localparam int PH2_LSB   = 16;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_KICK = 2'd1,
        REG_STAT = 2'd2
    } reg_addr_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic               en;
        logic [PRESC_W-1:0] presc;
        logic [MODE_W-1:0]  mode;
        logic [PHASE_W-1:0] ph1;
        logic [PHASE_W-1:0] ph2;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_tick_gen.sv
// Tick generator: divides the clock by 2^(BASE_SHIFT+presc).
// Assumes presc is stable while running; counter is held at zero when
// run is low and is zeroed by restart.
module wdt_tick_gen #(
    parameter int BASE_SHIFT = 25,
    parameter int PRESC_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick_o
);
    localparam int CNT_W = BASE_SHIFT + (1 << PRESC_W) - 1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Terminal count for the selected prescale.
    always_comb begin
        lim = (ONE << (BASE_SHIFT + int'(presc))) - ONE;
    end

    assign tick_o = run && (cnt == lim);

    // Divider counter: held, restarted or wrapped at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/wdt_phase_ctrl.sv
// Phase sequencer: counts ticks through the first phase, then the second,
// and issues a one-cycle reset request picked by mode. Assumes restart has
// priority over a tick arriving in the same cycle.
module wdt_phase_ctrl
    import wdt_pkg::*;
#(
    parameter int PH_W = PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [PH_W-1:0]   ph1_lim,
    input  logic [PH_W-1:0]   ph2_lim,
    input  logic [MODE_W-1:0] mode,
    output logic              ph1_exp,
    output logic              ph2_done,
    output logic [NUM_RST-1:0] rst_vec_o
);
    phase_e          st;
    logic [PH_W-1:0] cnt;
    logic            step;
    logic [NUM_RST-1:0] sel;

    assign step     = run && !restart && tick;
    assign ph1_exp  = step && (st == PH_FIRST)  && (cnt == ph1_lim);
    assign ph2_done = step && (st == PH_SECOND) && (cnt == ph2_lim);

    // Mode decode: one output per low code, the top output for the rest.
    generate
        for (genvar g = 0; g < NUM_RST; g++) begin : g_sel
            if (g < NUM_RST - 1) begin : g_exact
                assign sel[g] = (int'(mode) == g);
            end else begin : g_rest
                assign sel[g] = (int'(mode) >= g);
            end
        end
    endgenerate

    // Phase state and tick count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            st  <= PH_FIRST;
            cnt <= '0;
        end else if (ph1_exp) begin
            st  <= PH_SECOND;
            cnt <= '0;
        end else if (ph2_done) begin
            st  <= PH_FIRST;
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Registered one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_vec_o <= '0;
        end else begin
            rst_vec_o <= ph2_done ? sel : '0;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
// Register file: control word, kick decode, interrupt status with
// write-one-to-clear, and the lock that keeps the timer running after the
// first phase. Assumes single-cycle writes; reads are combinational.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] KICK_KEY = 32'h5A5A_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              ph1_exp,
    input  logic              ph2_done,
    output wdt_cfg_t          cfg,
    output logic              locked,
    output logic              irq,
    output logic              kick,
    output logic              run,
    output logic [DATA_W-1:0] rd_data
);
    logic wr_ctrl;
    logic wr_stat;

    assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
    assign wr_stat = wr_en && (wr_addr == REG_STAT);
    assign kick    = wr_en && (wr_addr == REG_KICK) && (wr_data == DATA_W'(KICK_KEY));
    assign run     = cfg.en || locked;

    // Control word; end of the second phase drops enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.en    <= wr_data[EN_BIT];
                cfg.presc <= wr_data[PRESC_LSB +: PRESC_W];
                cfg.mode  <= wr_data[MODE_LSB +: MODE_W];
                cfg.ph1   <= wr_data[PH1_LSB +: PHASE_W];
                cfg.ph2   <= wr_data[PH2_LSB +: PHASE_W];
            end
            if (ph2_done) begin
                cfg.en <= 1'b0;
            end
        end
    end

    // Lock: set at first expiry, released only by the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n || ph2_done) begin
            locked <= 1'b0;
        end else if (ph1_exp) begin
            locked <= 1'b1;
        end
    end

    // Interrupt flag: set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (ph1_exp) begin
            irq <= 1'b1;
        end else if (wr_stat && wr_data[0]) begin
            irq <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_CTRL: begin
                rd_data[EN_BIT]                 = cfg.en;
                rd_data[PRESC_LSB +: PRESC_W]   = cfg.presc;
                rd_data[MODE_LSB +: MODE_W]     = cfg.mode;
                rd_data[PH1_LSB +: PHASE_W]     = cfg.ph1;
                rd_data[PH2_LSB +: PHASE_W]     = cfg.ph2;
            end
            REG_STAT: begin
                rd_data[0] = irq;
                rd_data[1] = locked;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdt_two_phase.sv
// Top of the two-phase watchdog: register file, tick divider and phase
// sequencer. Assumes one clock domain and a synchronous active-low reset.
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int          BASE_SHIFT = 25,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] KICK_KEY   = 32'h5A5A_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              rst_cpu_o,
    output logic              rst_soc_o,
    output logic              rst_full_o
);
    wdt_cfg_t           cfg;
    logic               locked;
    logic               kick;
    logic               run;
    logic               tick;
    logic               ph1_exp;
    logic               ph2_done;
    logic [NUM_RST-1:0] rst_vec;

    wdt_regs #(
        .DATA_W   (DATA_W),
        .KICK_KEY (KICK_KEY)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .ph1_exp  (ph1_exp),
        .ph2_done (ph2_done),
        .cfg      (cfg),
        .locked   (locked),
        .irq      (irq_o),
        .kick     (kick),
        .run      (run),
        .rd_data  (rd_data)
    );

    wdt_tick_gen #(
        .BASE_SHIFT (BASE_SHIFT),
        .PRESC_W    (PRESC_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (kick),
        .presc   (cfg.presc),
        .tick_o  (tick)
    );

    wdt_phase_ctrl #(
        .PH_W (PHASE_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (kick),
        .tick      (tick),
        .ph1_lim   (cfg.ph1),
        .ph2_lim   (cfg.ph2),
        .mode      (cfg.mode),
        .ph1_exp   (ph1_exp),
        .ph2_done  (ph2_done),
        .rst_vec_o (rst_vec)
    );

    assign rst_cpu_o  = rst_vec[0];
    assign rst_soc_o  = rst_vec[1];
    assign rst_full_o = rst_vec[2];
endmodule

// File: rtl/wdt_two_phase_chk.sv
// Checker for the two-phase watchdog, bound into every instance of the top.
// Watches the outputs, the write port and the lock/enable state.
module wdt_two_phase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_o,
    input logic       rst_cpu_o,
    input logic       rst_soc_o,
    input logic       rst_full_o,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       wr_bit0,
    input logic       locked,
    input logic       ctrl_en
);
    logic any_rst;
    assign any_rst = rst_cpu_o || rst_soc_o || rst_full_o;

    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rst_cpu_o, rst_soc_o, rst_full_o}) <= 1); // R5
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> !any_rst); // R4
    AST_RST_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_rst) |-> $past(locked)); // R4
    AST_RST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |-> (!ctrl_en && !locked)); // R4
    AST_IRQ_WITH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> locked); // R3
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked || any_rst)); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_en && wr_addr == 2'd2 && wr_bit0)) |=> irq_o); // R9
endmodule

bind wdt_two_phase wdt_two_phase_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .rst_cpu_o  (rst_cpu_o),
    .rst_soc_o  (rst_soc_o),
    .rst_full_o (rst_full_o),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bit0    (wr_data[0]),
    .locked     (locked),
    .ctrl_en    (cfg.en)
);

// File: tb/wdt_two_phase_tb.sv
module wdt_two_phase_tb;
    localparam int          BS  = 2;
    localparam logic [31:0] KEY = 32'h5A5A_0001;

    typedef struct packed {
        logic [1:0] p;
        logic [4:0] f;
        logic [4:0] s;
        logic [1:0] m;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{p: 2'd0, f: 5'd2, s: 5'd1, m: 2'd0},
        '{p: 2'd1, f: 5'd0, s: 5'd3, m: 2'd1},
        '{p: 2'd2, f: 5'd1, s: 5'd0, m: 2'd2},
        '{p: 2'd3, f: 5'd0, s: 5'd0, m: 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        irq_o, rst_cpu_o, rst_soc_o, rst_full_o;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_two_phase #(.BASE_SHIFT(BS), .KICK_KEY(KEY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_o(irq_o), .rst_cpu_o(rst_cpu_o), .rst_soc_o(rst_soc_o),
        .rst_full_o(rst_full_o)
    );

    function automatic logic [31:0] ctl(input logic en, input logic [1:0] p,
                                        input logic [1:0] m, input logic [4:0] f,
                                        input logic [4:0] s);
        return (32'(s) << 16) | (32'(f) << 8) | (32'(m) << 3) | (32'(p) << 1) | 32'(en);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_irq(input int t0, input int lim, output int el);
        el = -1;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (irq_o) begin el = cyc - t0; break; end
        end
    endtask

    // Returns elapsed cycles, the reset outputs seen, and their width in cycles.
    task automatic wait_rst(input int t0, input int lim, output int el,
                            output logic [2:0] seen, output int width);
        el = -1; seen = 3'b000; width = 0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk); #1;
            if (rst_cpu_o || rst_soc_o || rst_full_o) begin
                el = cyc - t0;
                seen = {rst_full_o, rst_soc_o, rst_cpu_o};
                break;
            end
        end
        if (el >= 0) begin
            width = 1;
            @(posedge clk); #1;
            if (rst_cpu_o || rst_soc_o || rst_full_o) width = 2;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  seen;
        int t0, el, w, n1, n2, bad;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check(!irq_o, "R1 irq", int'(irq_o), 0);
        check(!(rst_cpu_o || rst_soc_o || rst_full_o), "R1 rst outs",
              int'({rst_full_o, rst_soc_o, rst_cpu_o}), 0);
        rd(2'd0, d); check(d == 0, "R1 ctrl", int'(d), 0);
        rd(2'd2, d); check(d == 0, "R1 status", int'(d), 0);

        // R2 R3 R4 R5 R9: vector table over all prescale settings
        foreach (VECS[k]) begin
            n1 = (int'(VECS[k].f) + 1) << (BS + int'(VECS[k].p));
            n2 = (int'(VECS[k].s) + 1) << (BS + int'(VECS[k].p));
            wr(2'd0, ctl(1'b1, VECS[k].p, VECS[k].m, VECS[k].f, VECS[k].s));
            t0 = cyc;
            wait_irq(t0, 500, el);
            check(el == n1, "R2 irq time", el, n1);
            rd(2'd2, d); check(d[1:0] == 2'b11, "R3 status", int'(d[1:0]), 3);
            wait_rst(t0, 500, el, seen, w);
            check(el == n1 + n2, "R4 rst time", el, n1 + n2);
            check(w == 1, "R4 pulse width", w, 1);
            check(seen == (VECS[k].m == 2'd0 ? 3'b001 : VECS[k].m == 2'd1 ? 3'b010 : 3'b100),
                  "R5 rst select", int'(seen),
                  int'(VECS[k].m == 2'd0 ? 3'b001 : VECS[k].m == 2'd1 ? 3'b010 : 3'b100));
            rd(2'd0, d); check(d[0] == 1'b0, "R4 enable cleared", int'(d[0]), 0);
            wr(2'd2, 32'h0000_0000);
            check(irq_o, "R9 write zero keeps", int'(irq_o), 1);
            wr(2'd2, 32'h0000_0001);
            check(!irq_o, "R9 write one clears", int'(irq_o), 0);
        end

        // R8 then R6: bad key ignored, then disable after expiry ignored
        wr(2'd0, ctl(1'b1, 2'd0, 2'd0, 5'd3, 5'd7));
        t0 = cyc;
        repeat (6) @(posedge clk);
        wr(2'd1, KEY ^ 32'h0000_0100);
        wait_irq(t0, 200, el);
        check(el == 16, "R8 bad key ignored", el, 16);
        wr(2'd0, ctl(1'b0, 2'd0, 2'd0, 5'd3, 5'd7));
        rd(2'd2, d); check(d[1] == 1'b1, "R6 lock set", int'(d[1]), 1);
        wait_rst(t0, 200, el, seen, w);
        check(el == 48, "R6 runs on after disable", el, 48);
        check(seen == 3'b001, "R6 rst cpu", int'(seen), 1);
        wr(2'd2, 32'h1);

        // R7: kick in first phase, then again in second phase
        wr(2'd0, ctl(1'b1, 2'd0, 2'd0, 5'd3, 5'd7));
        repeat (10) @(posedge clk);
        wr(2'd1, KEY);
        t0 = cyc;
        wait_irq(t0, 200, el);
        check(el == 16, "R7 kick phase 1", el, 16);
        repeat (5) @(posedge clk);
        wr(2'd2, 32'h1);
        wr(2'd1, KEY);
        t0 = cyc;
        wait_irq(t0, 200, el);
        check(el == 16, "R7 kick phase 2", el, 16);
        wait_rst(t0, 200, el, seen, w);
        check(el == 48, "R7 rst after kick", el, 48);
        wr(2'd2, 32'h1);

        // R10: disable before expiry stops everything; re-enable starts fresh
        wr(2'd0, ctl(1'b1, 2'd0, 2'd2, 5'd3, 5'd0));
        repeat (10) @(posedge clk);
        wr(2'd0, ctl(1'b0, 2'd0, 2'd2, 5'd3, 5'd0));
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            if (irq_o || rst_cpu_o || rst_soc_o || rst_full_o) bad++;
        end
        check(bad == 0, "R10 quiet while disabled", bad, 0);
        wr(2'd0, ctl(1'b1, 2'd0, 2'd2, 5'd3, 5'd0));
        t0 = cyc;
        wait_irq(t0, 200, el);
        check(el == 16, "R10 restart from zero", el, 16);
        wait_rst(t0, 200, el, seen, w);
        check(el == 20, "R10 rst time", el, 20);
        check(seen == 3'b100, "R10 rst full", int'(seen), 4);
        wr(2'd2, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule